// File: doc/BRIEF.md
# Pointer-Masking Control Register File

This block holds the architectural state of a pointer-masking feature on a processor that runs at three privilege levels: machine, supervisor and user. One machine-level control word carries a two-bit extension state and, per level, enable and "current" bits. The supervisor and user control registers are not separate storage. They are restricted windows onto that one word, and a write through a window changes only the bits that window exposes. Each privilege level also owns an XLEN-wide mask register and an XLEN-wide base register, which the address-masking datapath uses.

The CSR instruction decoder presents one request per cycle: a 12-bit CSR address, a read or write flag, write data and the current privilege level. It also supplies strap inputs that say whether the extension, supervisor mode and user mode exist. In the same cycle the block returns the register's prior contents, an illegal-instruction flag and a one-cycle pulse. That pulse tells the status register to mark extension state as dirty. Register updates take effect at the next clock edge. A write made at a register's own privilege level is silently dropped unless that level's "current" bit allows self-modification.

Top module: `pmask_csr_file`

## Requirements
- R1: The nine registers sit at addresses 0x7C0/0x7C1/0x7C2 (machine control/mask/base), 0x9C0/0x9C1/0x9C2 (supervisor) and 0x8C0/0x8C1/0x8C2 (user). The owning privilege is address bits [9:8] (3 machine, 1 supervisor, 0 user), and privilege is encoded the same way. A request to any other address returns zero, raises no fault and changes nothing.
- R2: The machine control view returns bits [6:0] of the control word: [1:0] extension state, bit 2 user enable, bit 3 user current, bit 4 supervisor enable, bit 5 supervisor current, bit 6 machine enable. All higher bits read zero and written values above bit 6 are discarded.
- R3: After reset the extension state reads 1 (initial), every other control bit reads 0, and all six mask/base registers read 0. The state encoding is 0 disabled, 1 initial, 2 clean, 3 dirty.
- R4: A supervisor control read returns only control bits [5:0]. A user control read returns only bits [3:2].
- R5: A supervisor or user control write replaces only the bits in its view and leaves the other control bits unchanged.
- R6: A write to a register owned by the current privilege is dropped without a fault, pulse or change unless the current privilege is machine, or it is supervisor with bit 5 set, or it is user with bit 3 set.
- R7: A write from a privilege above the register's owner is accepted regardless of the "current" bits.
- R8: Every accepted write to any of the nine registers sets the extension state to 3 by the next cycle and raises status_dirty_set for that request cycle only. Faulting or dropped requests never raise it.
- R9: With the extension absent, control reads return zero without a fault, while control writes and any mask/base access raise illegal.
- R10: Supervisor-owned registers raise illegal when supervisor mode is not implemented. User-owned registers raise illegal when user mode is not implemented. Machine registers are never blocked by these straps.
- R11: An access to a register owned by a higher privilege than the current one raises illegal, returns zero and changes nothing.
- R12: Mask and base registers store and return all XLEN bits unmodified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_present | input | 1 | Pointer-masking extension is implemented |
| s_impl | input | 1 | Supervisor mode is implemented |
| u_impl | input | 1 | User mode is implemented |
| priv | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| req_valid | input | 1 | CSR request present this cycle |
| req_write | input | 1 | Request is a write |
| req_addr | input | 12 | CSR address |
| req_wdata | input | XLEN | Write data |
| rd_data | output | XLEN | Prior register contents, zero on fault or miss |
| illegal | output | 1 | Request raises illegal instruction |
| status_dirty_set | output | 1 | Pulse asking the status register to set its XS and SD bits |

## Verification
The bench builds the block with XLEN set to 16, so every register value fits a short literal while the mask/base path still carries more than the seven control bits. For each setting of the three straps, it sweeps every privilege level, every "current" bit pair, all nine mapped addresses plus two unmapped ones, and both reads and writes. This brings every combination of ownership, strap fault, self-write gating and view merging within reach, and each access is followed by a machine-mode readback.

// File: rtl/pmask_pkg.sv
package pmask_pkg;

  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;

  localparam int CTRL_W = 7;
  localparam int NLVL   = 3;
  localparam int NXREG  = 2 * NLVL;
  localparam int XIDX_W = $clog2(NXREG);

  localparam logic [1:0] XS_INITIAL = 2'd1;
  localparam logic [1:0] XS_DIRTY   = 2'd3;

  localparam int BIT_U_CUR = 3;
  localparam int BIT_S_CUR = 5;

  localparam logic [CTRL_W-1:0] VIEW_M = 7'h7F;
  localparam logic [CTRL_W-1:0] VIEW_S = 7'h3F;
  localparam logic [CTRL_W-1:0] VIEW_U = 7'h0C;

  typedef struct packed {
    logic              hit;
    logic              is_ctrl;
    priv_e             owner;
    logic [XIDX_W-1:0] xidx;
  } csr_sel_t;

  function automatic logic [CTRL_W-1:0] view_of(priv_e lvl);
    case (lvl)
      PRIV_M:  view_of = VIEW_M;
      PRIV_S:  view_of = VIEW_S;
      PRIV_U:  view_of = VIEW_U;
      default: view_of = '0;
    endcase
  endfunction

endpackage

// File: rtl/pmask_rst_sync.sv
module pmask_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/pmask_addr_decode.sv
module pmask_addr_decode
  import pmask_pkg::*;
(
  input  logic [11:0] addr,
  output csr_sel_t    sel
);
  logic       grp_ok;
  logic       slot_ok;
  logic [1:0] lvl;

  always_comb begin
    grp_ok  = (addr[11:8] == 4'h7) || (addr[11:8] == 4'h8) || (addr[11:8] == 4'h9);
    slot_ok = (addr[7:2] == 6'b110000) && (addr[1:0] != 2'd3);
    // storage level: user 0, supervisor 1, machine 2
    lvl     = (addr[9:8] == 2'd3) ? 2'd2 : addr[9:8];
    sel.hit     = grp_ok && slot_ok;
    sel.is_ctrl = (addr[1:0] == 2'd0);
    sel.owner   = priv_e'(addr[9:8]);
    sel.xidx    = XIDX_W'({1'b0, lvl} * 3'd2 + {1'b0, addr[1:0]} - 3'd1);
  end
endmodule

// File: rtl/pmask_access_check.sv
module pmask_access_check
  import pmask_pkg::*;
(
  input  logic     req_valid,
  input  logic     req_write,
  input  csr_sel_t sel,
  input  logic [1:0] priv,
  input  logic     ext_present,
  input  logic     s_impl,
  input  logic     u_impl,
  input  logic     s_cur,
  input  logic     u_cur,
  output logic     illegal,
  output logic     accept
);
  logic above;
  logic strap_block;
  logic ext_block;
  logic self_block;

  always_comb begin
    above       = (sel.owner > priv_e'(priv));
    strap_block = ((sel.owner == PRIV_S) && !s_impl) ||
                  ((sel.owner == PRIV_U) && !u_impl);
    ext_block   = !ext_present && (!sel.is_ctrl || req_write);
    illegal     = req_valid && sel.hit && (above || strap_block || ext_block);
    self_block  = 1'b0;
    if (sel.owner == priv_e'(priv)) begin
      case (sel.owner)
        PRIV_S:  self_block = !s_cur;
        PRIV_U:  self_block = !u_cur;
        default: self_block = 1'b0;
      endcase
    end
    accept = req_valid && req_write && sel.hit && !illegal && !self_block;
  end
endmodule

// File: rtl/pmask_ctrl_reg.sv
module pmask_ctrl_reg
  import pmask_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any_accept,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] view,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] ctrl_q
);
  logic [CTRL_W-1:0] ctrl_d;
  logic              ctrl_en;

  always_comb begin
    ctrl_en = any_accept;
    ctrl_d  = ctrl_q;
    if (ctrl_wr) ctrl_d = (wdata & view) | (ctrl_q & ~view);
    ctrl_d[1:0] = XS_DIRTY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= {{(CTRL_W-2){1'b0}}, XS_INITIAL};
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/pmask_xreg_bank.sv
module pmask_xreg_bank
  import pmask_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr,
  input  logic [XIDX_W-1:0]           widx,
  input  logic [XLEN-1:0]             wdata,
  output logic [NXREG-1:0][XLEN-1:0]  regs_q
);
  for (genvar g = 0; g < NXREG; g++) begin : g_ent
    logic            en;
    logic [XLEN-1:0] d;

    always_comb begin
      en = wr && (widx == XIDX_W'(g));
      d  = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  regs_q[g] <= '0;
      else if (en) regs_q[g] <= d;
    end
  end
endmodule

// File: rtl/pmask_csr_file.sv
module pmask_csr_file
  import pmask_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_present,
  input  logic            s_impl,
  input  logic            u_impl,
  input  logic [1:0]      priv,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [11:0]     req_addr,
  input  logic [XLEN-1:0] req_wdata,
  output logic [XLEN-1:0] rd_data,
  output logic            illegal,
  output logic            status_dirty_set
);
  logic                       rst_sync_n;
  csr_sel_t                   sel;
  logic                       accept;
  logic [CTRL_W-1:0]          ctrl_q;
  logic [CTRL_W-1:0]          view;
  logic [NXREG-1:0][XLEN-1:0] xregs;

  pmask_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  pmask_addr_decode u_dec (
    .addr(req_addr), .sel(sel)
  );

  pmask_access_check u_chk (
    .req_valid(req_valid), .req_write(req_write), .sel(sel), .priv(priv),
    .ext_present(ext_present), .s_impl(s_impl), .u_impl(u_impl),
    .s_cur(ctrl_q[BIT_S_CUR]), .u_cur(ctrl_q[BIT_U_CUR]),
    .illegal(illegal), .accept(accept)
  );

  assign view = view_of(sel.owner);

  pmask_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .any_accept(accept),
    .ctrl_wr(accept && sel.is_ctrl), .view(view),
    .wdata(req_wdata[CTRL_W-1:0]), .ctrl_q(ctrl_q)
  );

  pmask_xreg_bank #(.XLEN(XLEN)) u_bank (
    .clk(clk), .rst_n(rst_sync_n), .wr(accept && !sel.is_ctrl),
    .widx(sel.xidx), .wdata(req_wdata), .regs_q(xregs)
  );

  always_comb begin
    rd_data = '0;
    if (req_valid && sel.hit && !illegal) begin
      if (sel.is_ctrl) begin
        if (ext_present) rd_data = {{(XLEN-CTRL_W){1'b0}}, ctrl_q & view};
      end else begin
        rd_data = xregs[sel.xidx];
      end
    end
    status_dirty_set = accept;
  end
endmodule

// File: rtl/pmask_csr_chk.sv
module pmask_csr_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      priv,
  input logic            ext_present,
  input logic            req_valid,
  input logic            req_write,
  input logic [11:0]     req_addr,
  input logic [XLEN-1:0] rd_data,
  input logic            illegal,
  input logic            status_dirty_set,
  input logic [6:0]      ctrl_q
);
  logic mapped;
  assign mapped = ((req_addr[11:8] == 4'h7) || (req_addr[11:8] == 4'h8) ||
                   (req_addr[11:8] == 4'h9)) &&
                  (req_addr[7:2] == 6'b110000) && (req_addr[1:0] != 2'd3);

  // R8
  dirty_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_dirty_set |=> (ctrl_q[1:0] == 2'd3));

  // R8
  no_pulse_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !status_dirty_set);

  // R11
  owner_above_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mapped && (req_addr[9:8] > priv)) |-> (illegal && rd_data == '0));

  // R9
  absent_xreg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mapped && req_addr[1:0] != 2'd0 && !ext_present) |-> illegal);

  // R6
  same_level_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && mapped && req_addr[9:8] == priv &&
     priv == 2'd1 && !ctrl_q[5]) |-> !status_dirty_set);

  // R1
  unmapped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !mapped) |-> (!illegal && !status_dirty_set && rd_data == '0));

  // R4
  user_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == 12'h8C0) |->
      (rd_data[XLEN-1:4] == '0 && rd_data[1:0] == 2'b00));
endmodule

bind pmask_csr_file pmask_csr_chk #(.XLEN(XLEN)) u_csr_chk (
  .clk(clk), .rst_n(rst_sync_n), .priv(priv), .ext_present(ext_present),
  .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
  .rd_data(rd_data), .illegal(illegal), .status_dirty_set(status_dirty_set),
  .ctrl_q(ctrl_q)
);

// File: tb/pmask_csr_file_test.sv
module pmask_csr_file_test;
  localparam int PERIOD = 10;
  localparam int XL = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ext_present = 1'b1, s_impl = 1'b1, u_impl = 1'b1;
  logic [1:0]    priv = 2'd3;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [11:0]   req_addr = '0;
  logic [XL-1:0] req_wdata = '0;
  logic [XL-1:0] rd_data;
  logic          illegal, status_dirty_set;

  int errors = 0;
  int checks = 0;
  logic [6:0]    m_ctrl;
  logic [XL-1:0] m_x [6];
  logic [XL-1:0] last_rd;

  always #(PERIOD/2) clk = ~clk;

  pmask_csr_file #(.XLEN(XL)) uut (
    .clk(clk), .rst_n(rst_n), .ext_present(ext_present), .s_impl(s_impl),
    .u_impl(u_impl), .priv(priv), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .illegal(illegal), .status_dirty_set(status_dirty_set)
  );

  task automatic chk(input string tag, input logic [XL-1:0] act, input logic [XL-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] viewm(input logic [1:0] own);
    case (own)
      2'd3:    return 7'h7F;
      2'd1:    return 7'h3F;
      2'd0:    return 7'h0C;
      default: return 7'h00;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_ctrl = 7'h01;
    for (int i = 0; i < 6; i++) m_x[i] = '0;
  endtask

  task automatic op(input logic [1:0] p, input logic [11:0] a, input bit we,
                    input logic [XL-1:0] wd);
    bit hit, ill, gated, acc;
    logic [1:0] own, idx, lvl;
    int xi;
    string itag, rtag;
    logic [XL-1:0] erd;
    @(negedge clk);
    priv = p; req_addr = a; req_write = we; req_wdata = wd; req_valid = 1'b1;
    hit = (a[11:8] == 4'h7 || a[11:8] == 4'h8 || a[11:8] == 4'h9) &&
          (a[7:2] == 6'h30) && (a[1:0] != 2'd3);
    own = a[9:8]; idx = a[1:0];
    lvl = (own == 2'd3) ? 2'd2 : own;
    xi  = int'(lvl) * 2 + int'(idx) - 1;
    ill = 0; itag = hit ? "R7" : "R1";
    if (hit) begin
      if (own > p) begin ill = 1; itag = "R11"; end
      else if ((own == 2'd1 && !s_impl) || (own == 2'd0 && !u_impl)) begin ill = 1; itag = "R10"; end
      else if (!ext_present && (idx != 2'd0 || we)) begin ill = 1; itag = "R9"; end
    end
    erd = '0;
    rtag = (idx == 2'd0) ? ((own == 2'd3) ? "R2" : "R4") : "R12";
    if (!hit) rtag = "R1";
    if (hit && !ill) begin
      if (idx == 2'd0) erd = ext_present ? {9'b0, m_ctrl & viewm(own)} : '0;
      else             erd = m_x[xi];
    end
    gated = hit && !ill && we && (own == p) && (p != 2'd3) &&
            !((p == 2'd1) ? m_ctrl[5] : m_ctrl[3]);
    if (gated) itag = "R6";
    acc = hit && !ill && we && !gated;
    #1;
    chk(itag, XL'(illegal), XL'(ill));
    chk(rtag, rd_data, erd);
    chk(gated ? "R6" : "R8", XL'(status_dirty_set), XL'(acc));
    last_rd = rd_data;
    @(posedge clk);
    if (acc) begin
      if (idx == 2'd0) m_ctrl = (wd[6:0] & viewm(own)) | (m_ctrl & ~viewm(own));
      else             m_x[xi] = wd;
      m_ctrl[1:0] = 2'd3;
    end
  endtask

  logic [11:0] addrs [11];
  initial begin
    addrs = '{12'h7C0, 12'h7C1, 12'h7C2, 12'h9C0, 12'h9C1, 12'h9C2,
              12'h8C0, 12'h8C1, 12'h8C2, 12'h7C3, 12'hAC0};
  end

  initial begin
    logic [XL-1:0] pat;
    pat = 16'hA5C3;
    do_reset();
    // R3: reset contents
    op(2'd3, 12'h7C0, 0, '0); chk("R3", last_rd, 16'h0001);
    op(2'd3, 12'h9C2, 0, '0); chk("R3", last_rd, 16'h0000);
    op(2'd3, 12'h8C1, 0, '0); chk("R3", last_rd, 16'h0000);
    // R2: reserved bits discarded, state forced dirty
    op(2'd3, 12'h7C0, 1, 16'hFF80); op(2'd3, 12'h7C0, 0, '0); chk("R2", last_rd, 16'h0003);
    // R5: merge through supervisor and user windows
    op(2'd3, 12'h7C0, 1, 16'h007F); op(2'd3, 12'h9C0, 1, 16'h0000);
    op(2'd3, 12'h7C0, 0, '0); chk("R5", last_rd, 16'h0043);
    op(2'd3, 12'h7C0, 1, 16'h007F); op(2'd3, 12'h8C0, 1, 16'hFFF3);
    op(2'd3, 12'h7C0, 0, '0); chk("R5", last_rd, 16'h0073);
    // R12: full-width storage
    op(2'd3, 12'h8C2, 1, 16'hFFFF); op(2'd3, 12'h8C2, 0, '0); chk("R12", last_rd, 16'hFFFF);

    // sweep
    for (int e = 0; e < 2; e++) begin
      ext_present = (e == 1);
      do_reset();
      for (int st = 0; st < 4; st++) begin
        s_impl = st[0]; u_impl = st[1];
        for (int pi = 0; pi < 3; pi++) begin
          logic [1:0] p;
          p = (pi == 2) ? 2'd3 : 2'(pi);
          for (int cur = 0; cur < 4; cur++) begin
            for (int ai = 0; ai < 11; ai++) begin
              for (int w = 0; w < 2; w++) begin
                op(2'd3, 12'h7C0, 1, XL'({1'b1, cur[1], 1'b1, cur[0], 1'b1, 2'b00}));
                pat = {pat[14:0], pat[15] ^ pat[13] ^ pat[12] ^ pat[10]};
                op(p, addrs[ai], w[0], pat);
                op(2'd3, addrs[ai], 0, '0);
              end
            end
          end
        end
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule